// File: doc/BRIEF.md
# Serial-to-parallel LED shift controller

This block drives a daisy chain of external 8-bit serial-in, parallel-out shift registers, typically used to fan a few chip pins out to many LEDs. Software writes a shadow output word through a small 32-bit register bus. The block then serialises the enabled part of that word onto a shift clock and a data line. It ends each transfer with a store pulse, so every parallel output changes at the same moment.

A transfer starts on a software request or on a tick from a periodic refresh timer. Up to three 8-bit groups make up the chain, and a group-enable mask sets the number of bits shifted. The lowest cascade bits can be handed to three status sources instead of CPU data. One is a two-bit DSL status input and two are two-bit PHY status inputs. A refreshing timer keeps those hardware-owned bits current without any software involvement.

The core is a four-state machine. The states are `S_IDLE`, `S_LAUNCH` (the data line takes a new bit and the shift clock sits at its launch level), `S_CAPTURE` (the clock sits at its capture level) and `S_STORE` (the store strobe is high). The transitions are:
- idle-to-launch: a request is pending and the chain is non-empty.
- launch-to-capture: after one half period.
- capture-to-launch: after one half period, when bits remain.
- capture-to-store: after one half period, when the last bit has gone out.
- store-to-idle: after one half period.

Top module: `sipo_led_ctrl`

## Requirements
- R1: After reset, offset 0x00 reads 0x8000_0000. Offsets 0x04, 0x08, 0x0C and 0x10 read zero. `busy` and `sh_store` are low, and `sh_clk` sits at the rising-edge idle level (low).
- R2: A write to offset 0x00 with bit 31 set requests one transfer. A write to 0x00 with bit 31 clear requests none.
- R3: Bits 2:0 at offset 0x04 enable groups 0..2. A transfer shifts 8 × (index of the highest enabled group + 1) bits. With the mask at zero a request is dropped and no store pulse occurs.
- R4: The frame is the low-order bits of offset 0x08, sent most significant bit first. A single store pulse follows the last bit.
- R5: Bit 26 at offset 0x00 selects the edge. When set, the data line changes on falling edges of `sh_clk` and the clock idles high. When clear, the data line changes on rising edges and the clock idles low.
- R6: Bits 25:24 at offset 0x00 give cascade bits 1:0 to `dsl_stat`. Each set bit replaces the CPU data bit with the matching input bit.
- R7: Bits 28:27 at offset 0x00 give cascade bits 3:2 to `phy1_stat`. Bits 16:15 at offset 0x04 give cascade bits 6:5 to `phy2_stat`, bit by bit.
- R8: When bits 31:30 at offset 0x04 equal 2'b10, a transfer is started every RATE_UNIT × {20, 10, 5, 4} clock cycles. The multiplier is picked by rate code 0, 1, 2 or 3 in bits 24:23 at offset 0x04. Any other source value stops the refresh.
- R9: Any number of requests made during a transfer produce exactly one further transfer after it.
- R10: Each half of the shift clock lasts CLK_DIV system clock cycles, so consecutive capture edges are 2 × CLK_DIV cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Bus access strobe |
| req_write | input | 1 | Bus access is a write |
| req_addr | input | 5 | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data for `req_addr` (combinational) |
| dsl_stat | input | 2 | DSL status bits for cascade bits 1:0 |
| phy1_stat | input | 2 | First PHY status bits for cascade bits 3:2 |
| phy2_stat | input | 2 | Second PHY status bits for cascade bits 6:5 |
| sh_clk | output | 1 | Shift clock to the cascade |
| sh_data | output | 1 | Serial data to the cascade |
| sh_store | output | 1 | Store strobe to the cascade |
| busy | output | 1 | A transfer is in progress |

## Verification
The hardest situation to reach from the ports is a request that arrives while a transfer is already running. The queue of depth one is only visible as the number of store pulses that follow. The stimulus waits until `busy` is seen high, issues two more software requests inside the same transfer, and then counts exactly one additional frame. The refresh period is measured from store pulse to store pulse once the timer has settled after a rate change. That avoids dependence on the phase of the prescaler at the moment the rate field was written.

// File: rtl/sipo_led_pkg.sv
package sipo_led_pkg;

    typedef enum logic [1:0] {
        S_IDLE,
        S_LAUNCH,
        S_CAPTURE,
        S_STORE
    } shift_state_t;

    localparam int ADDR_W = 5;
    localparam int WORD_W = 32;

    localparam logic [ADDR_W-1:0] OFS_CTRL_A  = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_CTRL_B  = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_DATA_LO = 5'h08;
    localparam logic [ADDR_W-1:0] OFS_DATA_HI = 5'h0C;
    localparam logic [ADDR_W-1:0] OFS_ACCESS  = 5'h10;

    // control word A fields
    localparam int A_SW_UPD  = 31;
    localparam int A_PHY1_LO = 27;
    localparam int A_EDGE    = 26;
    localparam int A_DSL_LO  = 24;
    // control word B fields
    localparam int B_SRC_LO  = 30;
    localparam int B_RATE_LO = 23;
    localparam int B_PHY2_LO = 15;

    localparam logic [WORD_W-1:0] CTRL_A_RST = 32'h8000_0000;
    localparam logic [1:0]        SRC_BUSCLK = 2'b10;

endpackage

// File: rtl/sipo_led_regs.sv
module sipo_led_regs
    import sipo_led_pkg::*;
#(
    parameter int CHAIN_W  = 24,
    parameter int N_GROUPS = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_valid,
    input  logic                bus_write,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [WORD_W-1:0]   bus_wdata,
    output logic [WORD_W-1:0]   bus_rdata,
    output logic [CHAIN_W-1:0]  shadow,
    output logic                edge_fall,
    output logic [1:0]          dsl_own,
    output logic [1:0]          phy1_own,
    output logic [1:0]          phy2_own,
    output logic [N_GROUPS-1:0] grp_mask,
    output logic [1:0]          rate_code,
    output logic                auto_en,
    output logic                sw_req,
    output logic                rate_reload
);

    logic [WORD_W-1:0] ctrl_a_q, ctrl_b_q, data_lo_q, data_hi_q, access_q;
    logic              wr;

    assign wr = bus_valid && bus_write;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_a_q  <= CTRL_A_RST;
            ctrl_b_q  <= '0;
            data_lo_q <= '0;
            data_hi_q <= '0;
            access_q  <= '0;
        end else if (wr) begin
            case (bus_addr)
                OFS_CTRL_A:  ctrl_a_q  <= bus_wdata;
                OFS_CTRL_B:  ctrl_b_q  <= bus_wdata;
                OFS_DATA_LO: data_lo_q <= bus_wdata;
                OFS_DATA_HI: data_hi_q <= bus_wdata;
                OFS_ACCESS:  access_q  <= bus_wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        case (bus_addr)
            OFS_CTRL_A:  bus_rdata = ctrl_a_q;
            OFS_CTRL_B:  bus_rdata = ctrl_b_q;
            OFS_DATA_LO: bus_rdata = data_lo_q;
            OFS_DATA_HI: bus_rdata = data_hi_q;
            OFS_ACCESS:  bus_rdata = access_q;
            default:     bus_rdata = '0;
        endcase
    end

    assign sw_req      = wr && (bus_addr == OFS_CTRL_A) && bus_wdata[A_SW_UPD];
    assign rate_reload = wr && (bus_addr == OFS_CTRL_B);

    assign shadow    = data_lo_q[CHAIN_W-1:0];
    assign edge_fall = ctrl_a_q[A_EDGE];
    assign dsl_own   = ctrl_a_q[A_DSL_LO +: 2];
    assign phy1_own  = ctrl_a_q[A_PHY1_LO +: 2];
    assign phy2_own  = ctrl_b_q[B_PHY2_LO +: 2];
    assign grp_mask  = ctrl_b_q[N_GROUPS-1:0];
    assign rate_code = ctrl_b_q[B_RATE_LO +: 2];
    assign auto_en   = (ctrl_b_q[B_SRC_LO +: 2] == SRC_BUSCLK);

endmodule

// File: rtl/sipo_led_rate_timer.sv
module sipo_led_rate_timer #(
    parameter int unsigned RATE_UNIT = 2_500_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic [1:0] rate_code,
    input  logic       reload,
    output logic       tick
);

    localparam int unsigned LIM_MAX = RATE_UNIT * 20;
    localparam int          CNT_W   = $clog2(LIM_MAX + 1);

    logic [CNT_W-1:0] cnt_q, limit;

    always_comb begin
        unique case (rate_code)
            2'd0: limit = CNT_W'(RATE_UNIT * 20);
            2'd1: limit = CNT_W'(RATE_UNIT * 10);
            2'd2: limit = CNT_W'(RATE_UNIT * 5);
            2'd3: limit = CNT_W'(RATE_UNIT * 4);
        endcase
    end

    assign tick = enable && (cnt_q == limit - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       cnt_q <= '0;
        else if (reload || !enable || tick) cnt_q <= '0;
        else                              cnt_q <= cnt_q + 1'b1;
    end

endmodule

// File: rtl/sipo_led_shifter.sv
module sipo_led_shifter
    import sipo_led_pkg::*;
#(
    parameter int GROUP_W  = 8,
    parameter int N_GROUPS = 3,
    parameter int CLK_DIV  = 50
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req,
    input  logic [GROUP_W*N_GROUPS-1:0] frame_in,
    input  logic [N_GROUPS-1:0]         grp_mask,
    input  logic                        edge_fall,
    output logic                        sh_clk,
    output logic                        sh_data,
    output logic                        sh_store,
    output logic                        busy
);

    localparam int CHAIN_W = GROUP_W * N_GROUPS;
    localparam int IDX_W   = $clog2(CHAIN_W);
    localparam int LEN_W   = $clog2(CHAIN_W + 1);
    localparam int GRP_W   = $clog2(N_GROUPS + 1);
    localparam int DIV_W   = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

    shift_state_t        state_q, state_d;
    logic [DIV_W-1:0]    div_q;
    logic [IDX_W-1:0]    idx_q, last_idx;
    logic [CHAIN_W-1:0]  frame_q;
    logic                pending_q, data_q;
    logic [GRP_W-1:0]    top_grp;
    logic [LEN_W-1:0]    len_bits;
    logic                half_done, take;

    // highest enabled group sets the chain length
    always_comb begin
        top_grp = '0;
        for (int g = 0; g < N_GROUPS; g++) begin
            if (grp_mask[g]) top_grp = GRP_W'(g + 1);
        end
    end

    assign len_bits  = LEN_W'(top_grp * GROUP_W);
    assign last_idx  = IDX_W'(len_bits - 1'b1);
    assign half_done = (div_q == DIV_W'(CLK_DIV - 1));
    assign take      = (state_q == S_IDLE) && pending_q && (len_bits != '0);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    if (take)      state_d = S_LAUNCH;
            S_LAUNCH:  if (half_done) state_d = S_CAPTURE;
            S_CAPTURE: if (half_done) state_d = (idx_q == '0) ? S_STORE : S_LAUNCH;
            S_STORE:   if (half_done) state_d = S_IDLE;
        endcase
    end

    // datapath: divider, request queue, frame and bit pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q     <= '0;
            pending_q <= 1'b0;
            idx_q     <= '0;
            frame_q   <= '0;
            data_q    <= 1'b0;
        end else begin
            // a pending request is consumed (or dropped on an empty chain) in idle
            pending_q <= req || (pending_q && (state_q != S_IDLE));
            if (state_q == S_IDLE || half_done) div_q <= '0;
            else                                div_q <= div_q + 1'b1;
            if (take) begin
                frame_q <= frame_in;
                idx_q   <= last_idx;
                data_q  <= frame_in[last_idx];
            end else if (state_q == S_CAPTURE && half_done && idx_q != '0) begin
                idx_q  <= idx_q - 1'b1;
                data_q <= frame_q[idx_q - 1'b1];
            end
        end
    end

    // outputs
    always_comb begin
        sh_clk   = edge_fall ? (state_q != S_LAUNCH) : (state_q == S_LAUNCH);
        sh_data  = data_q;
        sh_store = (state_q == S_STORE);
        busy     = (state_q != S_IDLE);
    end

endmodule

// File: rtl/sipo_led_ctrl.sv
module sipo_led_ctrl
    import sipo_led_pkg::*;
#(
    parameter int          GROUP_W   = 8,
    parameter int          N_GROUPS  = 3,
    parameter int          CLK_DIV   = 50,
    parameter int unsigned RATE_UNIT = 2_500_000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [4:0]  req_addr,
    input  logic [31:0] req_wdata,
    output logic [31:0] rd_data,
    input  logic [1:0]  dsl_stat,
    input  logic [1:0]  phy1_stat,
    input  logic [1:0]  phy2_stat,
    output logic        sh_clk,
    output logic        sh_data,
    output logic        sh_store,
    output logic        busy
);

    localparam int CHAIN_W = GROUP_W * N_GROUPS;

    logic [CHAIN_W-1:0]  shadow, own_mask, hw_bits, frame;
    logic                edge_fall, auto_en, sw_req, rate_reload, tick;
    logic [1:0]          dsl_own, phy1_own, phy2_own, rate_code;
    logic [N_GROUPS-1:0] grp_mask;

    sipo_led_regs #(.CHAIN_W(CHAIN_W), .N_GROUPS(N_GROUPS)) regs_i (
        .clk(clk), .rst_n(rst_n),
        .bus_valid(req_valid), .bus_write(req_write),
        .bus_addr(req_addr), .bus_wdata(req_wdata), .bus_rdata(rd_data),
        .shadow(shadow), .edge_fall(edge_fall),
        .dsl_own(dsl_own), .phy1_own(phy1_own), .phy2_own(phy2_own),
        .grp_mask(grp_mask), .rate_code(rate_code), .auto_en(auto_en),
        .sw_req(sw_req), .rate_reload(rate_reload)
    );

    sipo_led_rate_timer #(.RATE_UNIT(RATE_UNIT)) timer_i (
        .clk(clk), .rst_n(rst_n), .enable(auto_en),
        .rate_code(rate_code), .reload(rate_reload), .tick(tick)
    );

    // hardware sources: bits 1:0 DSL, 3:2 first PHY, 6:5 second PHY
    assign own_mask = CHAIN_W'({phy2_own,  1'b0, phy1_own,  dsl_own});
    assign hw_bits  = CHAIN_W'({phy2_stat, 1'b0, phy1_stat, dsl_stat});
    assign frame    = (shadow & ~own_mask) | (hw_bits & own_mask);

    sipo_led_shifter #(.GROUP_W(GROUP_W), .N_GROUPS(N_GROUPS), .CLK_DIV(CLK_DIV)) shift_i (
        .clk(clk), .rst_n(rst_n), .req(sw_req || tick),
        .frame_in(frame), .grp_mask(grp_mask), .edge_fall(edge_fall),
        .sh_clk(sh_clk), .sh_data(sh_data), .sh_store(sh_store), .busy(busy)
    );

endmodule

// File: rtl/sipo_led_ctrl_chk.sv
module sipo_led_ctrl_chk #(
    parameter int N_GROUPS = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic                busy,
    input logic                sh_clk,
    input logic                sh_data,
    input logic                sh_store,
    input logic                edge_fall,
    input logic [N_GROUPS-1:0] grp_mask
);

    // store pulse ends the transfer
    assert_store_ends_xfer_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sh_store) |-> !busy);

    // idle clock level follows the edge selection
    assert_idle_clk_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (sh_clk == edge_fall));

    // data only moves together with a shift-clock edge inside a transfer
    assert_data_moves_on_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && !$stable(sh_data)) |-> !$stable(sh_clk));

    // an empty chain never starts
    assert_empty_chain_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((grp_mask == '0) && !busy) |=> !busy);

endmodule

bind sipo_led_ctrl sipo_led_ctrl_chk #(.N_GROUPS(N_GROUPS)) chk_i (
    .clk(clk), .rst_n(rst_n), .busy(busy), .sh_clk(sh_clk),
    .sh_data(sh_data), .sh_store(sh_store),
    .edge_fall(edge_fall), .grp_mask(grp_mask)
);

// File: tb/sipo_led_ctrl_tb_top.sv
module sipo_led_ctrl_tb_top;

    localparam int CLK_DIV   = 2;
    localparam int RATE_UNIT = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [4:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] rd_data;
    logic [1:0]  dsl_stat = '0, phy1_stat = '0, phy2_stat = '0;
    logic        sh_clk, sh_data, sh_store, busy;

    always #5 clk = ~clk;

    sipo_led_ctrl #(.CLK_DIV(CLK_DIV), .RATE_UNIT(RATE_UNIT)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rd_data(rd_data),
        .dsl_stat(dsl_stat), .phy1_stat(phy1_stat), .phy2_stat(phy2_stat),
        .sh_clk(sh_clk), .sh_data(sh_data), .sh_store(sh_store), .busy(busy)
    );

    int checks = 0, failures = 0, cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // cascade model: captures bits on the capture edge, latches on store
    logic        mode_fall = 1'b0, prev_clk = 1'b0, prev_store = 1'b0;
    logic [23:0] cap = '0, last_frame = '0;
    int cap_n = 0, last_n = 0, frames = 0, store_cyc = 0, prev_store_cyc = 0;
    int last_cap_cyc = 0, period_err = 0;

    always @(negedge clk) begin
        if (busy && sh_clk != prev_clk && sh_clk == mode_fall) begin
            if (cap_n > 0 && cyc - last_cap_cyc != 2 * CLK_DIV) period_err++;
            cap = {cap[22:0], sh_data};
            cap_n++;
            last_cap_cyc = cyc;
        end
        if (sh_store && !prev_store) begin
            last_frame = cap; last_n = cap_n; frames++;
            prev_store_cyc = store_cyc; store_cyc = cyc;
            cap = '0; cap_n = 0;
        end
        prev_clk = sh_clk; prev_store = sh_store;
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic bus_rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        req_addr = a;
        #1 d = rd_data;
    endtask

    task automatic wait_idle();
        int quiet = 0;
        while (quiet < 4) begin
            @(negedge clk);
            if (!busy) quiet++; else quiet = 0;
        end
    endtask

    function automatic int top_group(input int m);
        if (m[2]) return 3;
        if (m[1]) return 2;
        if (m[0]) return 1;
        return 0;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] rv;
        int f0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        bus_rd(5'h00, rv); chk(rv == 32'h8000_0000, "R1 ctrl_a", rv, 32'h8000_0000);
        bus_rd(5'h04, rv); chk(rv == 0, "R1 ctrl_b", rv, 0);
        bus_rd(5'h08, rv); chk(rv == 0, "R1 data_lo", rv, 0);
        bus_rd(5'h0C, rv); chk(rv == 0, "R1 data_hi", rv, 0);
        bus_rd(5'h10, rv); chk(rv == 0, "R1 access", rv, 0);
        chk(!busy && !sh_store && !sh_clk, "R1 outputs", {busy, sh_store, sh_clk}, 0);

        // R2 R3 R4 R5: every group mask with both edges
        for (int e = 0; e < 2; e++) begin
            for (int m = 0; m < 8; m++) begin
                logic [23:0] pat, expf;
                int len;
                pat = 24'hC3A55A ^ (24'(m) * 24'h111111) ^ (e != 0 ? 24'hFFFFFF : 24'h0);
                len = 8 * top_group(m);
                expf = (len == 0) ? 24'h0 : (pat & 24'((64'd1 << len) - 1));
                f0 = frames;
                mode_fall = e[0];
                bus_wr(5'h04, 32'(m));
                bus_wr(5'h08, 32'(pat));
                bus_wr(5'h00, 32'h8000_0000 | (32'(e) << 26));
                wait_idle();
                if (m == 0) begin
                    chk(frames == f0, "R3 empty chain", frames - f0, 0);
                end else begin
                    chk(frames == f0 + 1, "R2 one transfer", frames - f0, 1);
                    chk(last_n == len, "R3 chain length", last_n, len);
                    chk(last_frame == expf, "R4 frame msb first", last_frame, expf);
                end
                chk(sh_clk == e[0], "R5 idle level", sh_clk, e);
            end
        end
        chk(period_err == 0, "R10 half period", period_err, 0);

        // R2: no transfer without the update bit
        f0 = frames;
        bus_wr(5'h04, 32'h7);
        bus_wr(5'h00, 32'h0400_0000);
        mode_fall = 1'b1;
        wait_idle();
        chk(frames == f0, "R2 no update bit", frames - f0, 0);

        // R6 R7: ownership sweep
        mode_fall = 1'b0;
        dsl_stat = 2'b01; phy1_stat = 2'b10; phy2_stat = 2'b01;
        for (int di = 0; di < 2; di++) begin
            for (int a = 0; a < 4; a++) begin
                for (int b = 0; b < 4; b++) begin
                    for (int c = 0; c < 4; c++) begin
                        logic [7:0] d, own, hwv, expb;
                        d    = (di != 0) ? 8'hFF : 8'h00;
                        own  = 8'((c << 5) | (b << 2) | a);
                        hwv  = 8'h29;
                        expb = (d & ~own) | (hwv & own);
                        bus_wr(5'h04, 32'h1 | (32'(c) << 15));
                        bus_wr(5'h08, 32'(d));
                        bus_wr(5'h00, 32'h8000_0000 | (32'(b) << 27) | (32'(a) << 24));
                        wait_idle();
                        chk(last_frame[7:0] == expb, "R6 R7 ownership", last_frame[7:0], expb);
                    end
                end
            end
        end

        // R9: requests during a transfer queue once
        bus_wr(5'h04, 32'h1);
        f0 = frames;
        bus_wr(5'h00, 32'h8000_0000);
        while (!busy) @(negedge clk);
        bus_wr(5'h00, 32'h8000_0000);
        bus_wr(5'h00, 32'h8000_0000);
        wait_idle();
        chk(frames == f0 + 2, "R9 queued once", frames - f0, 2);

        // R8: automatic refresh at each rate
        bus_wr(5'h00, 32'h0);
        for (int code = 0; code < 4; code++) begin
            int mult, guard;
            mult = (code == 0) ? 20 : (code == 1) ? 10 : (code == 2) ? 5 : 4;
            bus_wr(5'h04, (32'h2 << 30) | (32'(code) << 23) | 32'h1);
            f0 = frames;
            guard = 0;
            while (frames < f0 + 3 && guard < 5000) begin
                @(negedge clk);
                guard++;
            end
            chk(store_cyc - prev_store_cyc == RATE_UNIT * mult, "R8 refresh period",
                store_cyc - prev_store_cyc, RATE_UNIT * mult);
        end
        bus_wr(5'h04, (32'h1 << 30) | (32'h3 << 23) | 32'h1);
        wait_idle();
        f0 = frames;
        repeat (400) @(negedge clk);
        chk(frames == f0, "R8 refresh off", frames - f0, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule